// File: doc/BRIEF.md
# SPI Flash Host Controller

This block is the host-side engine that carries out serial flash operations over a single data lane in SPI mode 0. A client presents one request at a time with an operation, a 24-bit address and a byte count. The controller then builds every chip-select frame the operation needs, with no further help from the client. Write data for a program is pulled from the client one byte at a time through a take strobe. Read data is handed back one byte at a time through a valid strobe.

For any operation that changes the array, the controller first sends a one-byte write-enable frame. It then sends the command frame, and after that it keeps issuing status reads until the device reports that it is idle. Only then does it signal completion. If the device stays busy for more than a set number of polls, the controller reports a timeout instead. Requests whose length or page placement is illegal are refused at once, and no bus traffic results. The SPI clock rate is a parameter: each SPI clock phase lasts a fixed number of system clocks. The minimum chip-select high time between frames is also a parameter.

Top module: `spi_flash_host`

## Requirements
- R1: The serial clock is low whenever chip select is high, and the device samples on its rising edge. Every byte is shifted out most significant bit first. The returned bit is captured on the same rising edge.
- R2: Before each program (op 1), sector erase (op 2), block erase (op 3) or chip erase (op 4), a frame holding only the byte 06h is sent. It has its own chip-select low period.
- R3: A command frame starts with its command byte: 03h read, 02h program, 20h sector erase, D8h block erase, C7h chip erase. For all but chip erase, three address bytes follow, high byte first. A chip erase frame is one byte long.
- R4: For a sector erase the address is sent with bits 11:0 cleared. For a block erase it is sent with bits 15:0 cleared. Read and program addresses are sent unchanged.
- R5: A program frame carries exactly len data bytes after the address. These bytes are taken in order, one per wr_take pulse.
- R6: A read (op 0) sends no dummy byte after the address and keeps chip select low for exactly len returned bytes. Each returned byte appears on rd_data with a one-cycle rd_valid pulse.
- R7: A request is refused with a one-cycle err pulse, err_code 1, and no chip-select activity in any of these cases:
  - the op is 5 to 7;
  - a read or program has len 0 or len above 256;
  - a program would run past the end of its 256-byte page, meaning addr[7:0] + len > 256.
- R8: After the command frame of a modifying op, status frames (05h followed by one read byte) repeat while bit 0 of the returned byte is 1. The first status byte with bit 0 clear ends the op with a one-cycle done pulse. Non-modifying reads pulse done after their frame.
- R9: If POLL_LIMIT consecutive status bytes all show busy, the op ends with an err pulse and err_code 2, and done does not pulse.
- R10: Chip select stays high for at least CS_GAP system clocks between any two frames.
- R11: After reset: spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done, err, rd_valid and wr_take are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| req_addr | input | 24 | Byte address |
| req_len | input | 9 | Byte count for read or program, 1 to 256 |
| wr_data | input | 8 | Next program byte, must be stable when wr_take is high |
| wr_take | output | 1 | Program byte consumed this cycle |
| rd_valid | output | 1 | rd_data holds a returned read byte |
| rd_data | output | 8 | Returned read byte |
| done | output | 1 | Operation finished successfully (pulse) |
| err | output | 1 | Operation refused or timed out (pulse) |
| err_code | output | 2 | 1 illegal request, 2 busy timeout |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Data to device |
| spi_miso | input | 1 | Data from device |

## Verification
The engine is driven with reads at two addresses and lengths, and with programs of 8 bytes, a full aligned page and a single byte at the last page offset. It is also driven with erases whose addresses have low bits set, and with a chip erase. Together these separate address alignment, the sequences with and without an address, and data counting at the page edge. The busy depths of the device model vary from 0 to 3 polls, and one case stays busy beyond the poll limit, which separates normal completion from timeout. Illegal requests cover a page crossing, zero and oversized lengths, and an unknown op. A model that records every frame shows which of these slipped onto the bus.

// File: rtl/sfh_pkg.sv
package sfh_pkg;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_SERASE = 3'd2;
  localparam logic [2:0] OP_BERASE = 3'd3;
  localparam logic [2:0] OP_CERASE = 3'd4;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_REQUEST = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  localparam int PAGE_BYTES = 256;

  typedef enum logic [1:0] {FR_WREN, FR_CMD, FR_POLL} sfh_frame_e;

  function automatic logic [7:0] sfh_cmd(input logic [2:0] op);
    case (op)
      OP_READ:   return 8'h03;
      OP_PROG:   return 8'h02;
      OP_SERASE: return 8'h20;
      OP_BERASE: return 8'hD8;
      default:   return 8'hC7;
    endcase
  endfunction

  function automatic logic sfh_modifies(input logic [2:0] op);
    return op != OP_READ;
  endfunction

  function automatic logic sfh_has_data(input logic [2:0] op);
    return (op == OP_READ) || (op == OP_PROG);
  endfunction

  function automatic logic [23:0] sfh_align(input logic [2:0] op, input logic [23:0] a);
    case (op)
      OP_SERASE: return {a[23:12], 12'h000};
      OP_BERASE: return {a[23:16], 16'h0000};
      default:   return a;
    endcase
  endfunction

  function automatic logic sfh_legal(input logic [2:0] op, input logic [23:0] a,
                                     input logic [8:0] len);
    logic [9:0] end_off;
    end_off = {2'b00, a[7:0]} + {1'b0, len};
    if (op > OP_CERASE) return 1'b0;
    if (sfh_has_data(op) && (len == 9'd0 || len > 9'(PAGE_BYTES))) return 1'b0;
    if (op == OP_PROG && end_off > 10'(PAGE_BYTES)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [9:0] sfh_last_idx(input sfh_frame_e fr, input logic [2:0] op,
                                              input logic [8:0] len);
    case (fr)
      FR_WREN: return 10'd0;
      FR_POLL: return 10'd1;
      default: begin
        if (op == OP_CERASE) return 10'd0;
        if (sfh_has_data(op)) return 10'd3 + {1'b0, len};
        return 10'd3;
      end
    endcase
  endfunction

  function automatic logic [7:0] sfh_byte(input sfh_frame_e fr, input logic [2:0] op,
                                          input logic [23:0] a, input logic [9:0] idx,
                                          input logic [7:0] wdata);
    case (fr)
      FR_WREN: return 8'h06;
      FR_POLL: return (idx == 10'd0) ? 8'h05 : 8'h00;
      default: begin
        case (idx)
          10'd0:   return sfh_cmd(op);
          10'd1:   return a[23:16];
          10'd2:   return a[15:8];
          10'd3:   return a[7:0];
          default: return (op == OP_PROG) ? wdata : 8'h00;
        endcase
      end
    endcase
  endfunction

endpackage

// File: rtl/sfh_shifter.sv
module sfh_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       active,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic [2:0]    bits;
  logic [7:0]    sh;
  logic          phase_end;

  assign phase_end = (cnt == DIV_LAST);
  assign mosi      = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      byte_done <= 1'b0;
      rx_byte   <= 8'h00;
      sck       <= 1'b0;
      sh        <= 8'h00;
      cnt       <= '0;
      bits      <= 3'd0;
    end else begin
      byte_done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh     <= tx_byte;
        cnt    <= '0;
        sck    <= 1'b0;
        bits   <= 3'd0;
      end else if (active) begin
        if (phase_end) begin
          cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bits == 3'd7) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bits <= bits + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  a_r1_byte_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !sck);

endmodule

// File: rtl/sfh_gap_timer.sv
module sfh_gap_timer #(
  parameter int CS_GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic gap_ok
);
  localparam int GW = $clog2(CS_GAP + 1) + 1;
  localparam logic [GW-1:0] GAP_MIN = GW'(CS_GAP);

  logic [GW-1:0] high_cnt;

  assign gap_ok = (high_cnt >= GAP_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        high_cnt <= '0;
    else if (!cs_n)    high_cnt <= '0;
    else if (!gap_ok)  high_cnt <= high_cnt + GW'(1);
  end

endmodule

// File: rtl/sfh_sequencer.sv
module sfh_sequencer
  import sfh_pkg::*;
#(
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_addr,
  input  logic [8:0]  req_len,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code,
  output logic        cs_n,
  input  logic        gap_ok,
  output logic        sh_start,
  output logic [7:0]  sh_tx,
  input  logic        sh_done,
  input  logic [7:0]  sh_rx
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(POLL_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LOAD, S_WAIT, S_END} state_e;

  state_e      state;
  sfh_frame_e  frame;
  logic [2:0]  op_q;
  logic [23:0] addr_q;
  logic [8:0]  len_q;
  logic [9:0]  idx;
  logic [PW-1:0] poll_cnt;
  logic        stat_busy;
  logic        wren_sent;

  logic        req_legal;
  logic [9:0]  last_idx;
  logic        frame_last_byte;
  logic        is_data_byte;

  assign req_ready       = (state == S_IDLE);
  assign req_legal       = sfh_legal(req_op, req_addr, req_len);
  assign last_idx        = sfh_last_idx(frame, op_q, len_q);
  assign frame_last_byte = (idx == last_idx);
  assign is_data_byte    = (frame == FR_CMD) && (idx >= 10'd4);
  assign sh_start        = (state == S_LOAD);
  assign sh_tx           = sfh_byte(frame, op_q, addr_q, idx, wr_data);
  assign wr_take         = sh_start && is_data_byte && (op_q == OP_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      frame     <= FR_WREN;
      op_q      <= OP_READ;
      addr_q    <= 24'h0;
      len_q     <= 9'd0;
      idx       <= 10'd0;
      poll_cnt  <= '0;
      stat_busy <= 1'b0;
      wren_sent <= 1'b0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= ERR_NONE;
      rd_valid  <= 1'b0;
      rd_data   <= 8'h00;
    end else begin
      done     <= 1'b0;
      err      <= 1'b0;
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          wren_sent <= 1'b0;
          if (req_valid) begin
            if (req_legal) begin
              op_q     <= req_op;
              addr_q   <= sfh_align(req_op, req_addr);
              len_q    <= req_len;
              frame    <= sfh_modifies(req_op) ? FR_WREN : FR_CMD;
              err_code <= ERR_NONE;
              state    <= S_GAP;
            end else begin
              err      <= 1'b1;
              err_code <= ERR_REQUEST;
            end
          end
        end
        S_GAP: begin
          if (gap_ok) begin
            cs_n  <= 1'b0;
            idx   <= 10'd0;
            state <= S_LOAD;
          end
        end
        S_LOAD: state <= S_WAIT;
        S_WAIT: begin
          if (sh_done) begin
            if (is_data_byte && op_q == OP_READ) begin
              rd_valid <= 1'b1;
              rd_data  <= sh_rx;
            end
            if (frame == FR_POLL && idx == 10'd1) stat_busy <= sh_rx[0];
            if (frame_last_byte) begin
              cs_n  <= 1'b1;
              state <= S_END;
            end else begin
              idx   <= idx + 10'd1;
              state <= S_LOAD;
            end
          end
        end
        S_END: begin
          case (frame)
            FR_WREN: begin
              wren_sent <= 1'b1;
              frame     <= FR_CMD;
              state     <= S_GAP;
            end
            FR_CMD: begin
              if (sfh_modifies(op_q)) begin
                frame    <= FR_POLL;
                poll_cnt <= '0;
                state    <= S_GAP;
              end else begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
            end
            default: begin
              if (!stat_busy) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else if (poll_cnt == POLL_LAST) begin
                err      <= 1'b1;
                err_code <= ERR_TIMEOUT;
                state    <= S_IDLE;
              end else begin
                poll_cnt <= poll_cnt + PW'(1);
                state    <= S_GAP;
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7: a refused request leaves the bus untouched
  a_r7_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && !req_legal) |=> (state == S_IDLE && cs_n));

  // R10: chip select only falls once the gap timer agrees
  a_r10_gap_before_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(gap_ok));

  // R2: a modifying command frame opens only after its enable frame
  a_r2_wren_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && frame == FR_CMD && sfh_modifies(op_q)) |-> wren_sent);

  // R5: write bytes are consumed only inside a program frame
  a_r5_take_in_program: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (op_q == OP_PROG && frame == FR_CMD && !cs_n));

  // R9: completion and failure never coincide
  a_r9_done_err_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9: a timeout only follows the final permitted poll
  a_r9_timeout_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (err && err_code == ERR_TIMEOUT) |-> (poll_cnt == POLL_LAST));

endmodule

// File: rtl/spi_flash_host.sv
module spi_flash_host #(
  parameter int CLK_DIV    = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_addr,
  input  logic [8:0]  req_len,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_code,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic       gap_ok;
  logic       sh_start;
  logic [7:0] sh_tx;
  logic       sh_active;
  logic       sh_done;
  logic [7:0] sh_rx;

  sfh_gap_timer #(.CS_GAP(CS_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (spi_cs_n),
    .gap_ok (gap_ok)
  );

  sfh_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sh_start),
    .tx_byte   (sh_tx),
    .miso      (spi_miso),
    .active    (sh_active),
    .byte_done (sh_done),
    .rx_byte   (sh_rx),
    .sck       (spi_sck),
    .mosi      (spi_mosi)
  );

  sfh_sequencer #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .wr_data   (wr_data),
    .wr_take   (wr_take),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .done      (done),
    .err       (err),
    .err_code  (err_code),
    .cs_n      (spi_cs_n),
    .gap_ok    (gap_ok),
    .sh_start  (sh_start),
    .sh_tx     (sh_tx),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx)
  );

  // R1: serial clock rests low outside a frame
  a_r1_sck_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R1: no byte starts while the previous one is still shifting
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_active);

endmodule

// File: tb/tb_spi_flash_host.sv
module tb_spi_flash_host;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP = 3;
  localparam int POLL_LIMIT = 8;

  typedef struct packed {
    logic [2:0]  op;
    logic [23:0] addr;
    logic [8:0]  len;
    logic [4:0]  busy;
    logic        bad;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 24'h000010, 9'd4,   5'd0, 1'b0},
    '{3'd0, 24'h0000F0, 9'd16,  5'd0, 1'b0},
    '{3'd1, 24'h000120, 9'd8,   5'd2, 1'b0},
    '{3'd1, 24'h000200, 9'd256, 5'd1, 1'b0},
    '{3'd1, 24'h0003FF, 9'd1,   5'd0, 1'b0},
    '{3'd2, 24'h123456, 9'd0,   5'd3, 1'b0},
    '{3'd3, 24'h3ABCDE, 9'd0,   5'd1, 1'b0},
    '{3'd4, 24'h0055AA, 9'd0,   5'd2, 1'b0},
    '{3'd1, 24'h0001F0, 9'd17,  5'd0, 1'b1},
    '{3'd0, 24'h000000, 9'd0,   5'd0, 1'b1},
    '{3'd1, 24'h000000, 9'd257, 5'd0, 1'b1},
    '{3'd5, 24'h000000, 9'd4,   5'd0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [23:0] req_addr = 24'h0;
  logic [8:0] req_len = 9'd0;
  logic [7:0] wr_data;
  logic req_ready, wr_take, rd_valid, done, err;
  logic [7:0] rd_data;
  logic [1:0] err_code;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_flash_host #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .err(err), .err_code(err_code), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // client-side write stream and read capture
  logic [7:0] pat [256];
  logic clr = 1'b0;
  int wr_idx = 0;
  int rd_n = 0;
  logic [7:0] rd_buf [256];
  assign wr_data = pat[wr_idx[7:0]];
  always @(posedge clk) begin
    if (clr) begin wr_idx <= 0; rd_n <= 0; end
    else begin
      if (wr_take) wr_idx <= wr_idx + 1;
      if (rd_valid) begin rd_buf[rd_n[7:0]] <= rd_data; rd_n <= rd_n + 1; end
    end
  end

  // watchdog and bus-level observers
  int cyc = 0;
  int hi_run = 0;
  int min_gap = 1000;
  int frames_seen = 0;
  logic sck_bad = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      report();
    end
  end
  always @(negedge clk) begin
    if (rst_n && spi_cs_n && spi_sck) sck_bad = 1'b1;
    if (rst_n && spi_cs_n) hi_run++;
    else if (rst_n && !spi_cs_n && hi_run != 0) begin
      if (frames_seen != 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  // device model
  logic [7:0] mem [4096];
  logic in_frame = 1'b0;
  int bitc = 0, bytec = 0;
  logic [7:0] rx_sh = 8'h00, tx_cur = 8'h00, cmd = 8'h00;
  logic [23:0] cur_addr = 24'h0, rd_ptr = 24'h0;
  int busy_cfg = 0, busy_left = 0, polls = 0, prog_n = 0;
  logic prev_wren = 1'b0;
  logic [7:0] fr_cmd = 8'h00;
  logic [23:0] fr_addr = 24'h0;
  int fr_bytes = 0, big_frames = 0;
  logic fr_wren_ok = 1'b0;

  always @(negedge spi_cs_n) begin
    if (rst_n) begin in_frame = 1'b1; bitc = 0; bytec = 0; frames_seen++; end
  end
  always @(posedge spi_sck) begin
    if (in_frame) begin
      rx_sh = {rx_sh[6:0], spi_mosi};
      bitc++;
      if (bitc == 8) begin
        bitc = 0;
        if (bytec == 0) begin
          cmd = rx_sh;
          if (cmd == 8'h05) begin
            tx_cur = {7'd0, busy_left != 0};
            if (busy_left > 0) busy_left--;
          end
        end else if (bytec <= 3) begin
          cur_addr = {cur_addr[15:0], rx_sh};
          if (bytec == 3 && cmd == 8'h03) begin
            rd_ptr = cur_addr; tx_cur = mem[rd_ptr[11:0]]; rd_ptr++;
          end
        end else if (cmd == 8'h03) begin
          tx_cur = mem[rd_ptr[11:0]]; rd_ptr++;
        end else if (cmd == 8'h02) begin
          mem[{cur_addr[11:8], 8'(cur_addr[7:0] + 8'(bytec - 4))}] = rx_sh;
          prog_n++;
        end
        bytec++;
      end
    end
  end
  always @(negedge spi_sck) begin
    if (in_frame) spi_miso = tx_cur[3'(7 - bitc)];
  end
  always @(posedge spi_cs_n) begin
    if (in_frame) begin
      in_frame = 1'b0;
      if (cmd == 8'h05) polls++;
      else if (!(cmd == 8'h06 && bytec == 1)) begin
        fr_cmd = cmd; fr_addr = cur_addr; fr_bytes = bytec; fr_wren_ok = prev_wren;
        big_frames++;
        if (cmd != 8'h03) busy_left = busy_cfg;
      end
      prev_wren = (cmd == 8'h06 && bytec == 1);
    end
  end

  task automatic issue(input logic [2:0] op, input logic [23:0] a, input logic [8:0] len);
    @(negedge clk);
    clr = 1'b1; req_valid = 1'b1; req_op = op; req_addr = a; req_len = len;
    @(negedge clk);
    clr = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err, output logic [1:0] code);
    got_done = 0; got_err = 0; code = 2'd0;
    if (err) begin got_err = 1; code = err_code; return; end
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done || err) begin got_done = done; got_err = err; code = err_code; return; end
    end
  endtask

  function automatic logic [7:0] exp_cmd(input logic [2:0] op);
    case (op) 0: return 8'h03; 1: return 8'h02; 2: return 8'h20; 3: return 8'hD8; default: return 8'hC7; endcase
  endfunction

  function automatic logic [23:0] exp_addr(input logic [2:0] op, input logic [23:0] a);
    if (op == 3'd2) return a & 24'hFFF000;
    if (op == 3'd3) return a & 24'hFF0000;
    return a;
  endfunction

  initial begin
    bit gd, ge;
    logic [1:0] gc;
    for (int i = 0; i < 256; i++) pat[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R11: state held during reset
    chk(spi_cs_n === 1'b1, "R11 cs_n in reset", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R11 sck in reset", spi_sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11 req_ready", req_ready, 1);
    chk({done, err, rd_valid, wr_take} === 4'b0, "R11 strobes", {done, err, rd_valid, wr_take}, 0);

    for (int v = 0; v < NV; v++) begin
      int fr0, pol0, big0;
      busy_cfg = int'(VECS[v].busy);
      polls = 0; prog_n = 0;
      fr0 = frames_seen; big0 = big_frames;
      if (VECS[v].op == 3'd0)
        for (int j = 0; j < 4096; j++) mem[j] = 8'(j ^ (j >> 4) ^ 8'h5A);
      issue(VECS[v].op, VECS[v].addr, VECS[v].len);
      wait_end(gd, ge, gc);
      pol0 = polls;
      if (VECS[v].bad) begin
        chk(ge && gc == 2'd1, "R7 refused with code 1", {ge, gc}, 3'b101);
        chk(frames_seen == fr0, "R7 no frame for refused request", frames_seen - fr0, 0);
      end else begin
        chk(gd && !ge, "R8 done pulse", {gd, ge}, 2'b10);
        chk(big_frames == big0 + 1, "R3 one command frame", big_frames - big0, 1);
        chk(fr_cmd == exp_cmd(VECS[v].op), "R3 command byte", fr_cmd, exp_cmd(VECS[v].op));
        if (VECS[v].op == 3'd4)
          chk(fr_bytes == 1, "R3 chip erase one byte", fr_bytes, 1);
        else
          chk(fr_addr == exp_addr(VECS[v].op, VECS[v].addr), "R4 address sent",
              fr_addr, exp_addr(VECS[v].op, VECS[v].addr));
        if (VECS[v].op != 3'd0) begin
          chk(fr_wren_ok == 1'b1, "R2 enable frame before command", fr_wren_ok, 1);
          chk(pol0 == int'(VECS[v].busy) + 1, "R8 status polls", pol0, int'(VECS[v].busy) + 1);
        end else begin
          chk(pol0 == 0, "R8 no polls for read", pol0, 0);
          chk(fr_bytes == 4 + int'(VECS[v].len), "R6 frame length no dummy",
              fr_bytes, 4 + int'(VECS[v].len));
          chk(rd_n == int'(VECS[v].len), "R6 byte count", rd_n, int'(VECS[v].len));
          for (int j = 0; j < int'(VECS[v].len); j++) begin
            logic [11:0] aj;
            logic [7:0] ex;
            aj = 12'(VECS[v].addr + 24'(j));
            ex = 8'(int'(aj) ^ (int'(aj) >> 4) ^ 8'h5A);
            if (rd_buf[j] !== ex) chk(0, "R6 R1 read data", rd_buf[j], ex);
          end
        end
        if (VECS[v].op == 3'd1) begin
          chk(prog_n == int'(VECS[v].len), "R5 program byte count", prog_n, int'(VECS[v].len));
          chk(wr_idx == int'(VECS[v].len), "R5 take pulses", wr_idx, int'(VECS[v].len));
          for (int j = 0; j < int'(VECS[v].len); j++) begin
            logic [11:0] aj;
            aj = 12'(VECS[v].addr + 24'(j));
            if (mem[aj] !== pat[j]) chk(0, "R5 R1 program data", mem[aj], pat[j]);
          end
        end
      end
    end

    // R9: device stays busy past the limit
    busy_cfg = 20; polls = 0;
    issue(3'd2, 24'h001000, 9'd0);
    wait_end(gd, ge, gc);
    chk(ge && !gd && gc == 2'd2, "R9 timeout error", {gd, ge, gc}, 4'b0110);
    chk(polls == POLL_LIMIT, "R9 poll count at timeout", polls, POLL_LIMIT);

    // R1 and R10 bus-wide observations
    chk(!sck_bad, "R1 sck low while deselected", sck_bad, 0);
    chk(min_gap >= CS_GAP, "R10 minimum deselect time", min_gap, CS_GAP);
    @(negedge clk);
    chk(req_ready === 1'b1 && spi_cs_n === 1'b1, "R11 idle after timeout", {req_ready, spi_cs_n}, 2'b11);
    report();
  end

endmodule